// File: doc/BRIEF.md
# Vectored Interrupt Entry Unit

This unit sits between a bank of up to 128 interrupt request lines and a processor core. When entry is enabled and at least one line is raised, it picks the lowest-numbered pending source. It then forms the address of that source's handler and gives the core a one-cycle strobe carrying that address. The handler address comes from one of two places. A device may drive its own 32-bit vector on the data bus in the same cycle it raises its request, marked by a valid qualifier, and the unit captures it in that cycle without any acknowledge cycle. If no device drives a vector, the unit reads a default entry from a vector table in memory through a synchronous read port with one cycle of latency.

Bit 0 of the selected vector chooses which of the core's two identical register banks the handler runs in. A 0 selects the primary bank and a 1 selects the alternate bank. Bit 0 is cleared before the vector is handed out as the handler address. The unit holds the current bank select and the value it had before the last entry, so that a later return can restore it. Software may also write the bank select directly.

The controller is a three-state machine with states `S_IDLE`, `S_FETCH` and `S_TAKE`, and four transitions:
- *direct* (`S_IDLE`→`S_TAKE`): entry is enabled, a request is pending and the vector is valid on the bus.
- *table* (`S_IDLE`→`S_FETCH`): entry is enabled, a request is pending and no valid vector is on the bus. The table read is issued in this cycle.
- *loaded* (`S_FETCH`→`S_TAKE`): the table data has returned.
- *done* (`S_TAKE`→`S_IDLE`): the strobe has been given.

Top module: `irq_entry_unit`

## Requirements
- R1: After reset the following are all 0: `take_irq`, `tbl_rd_en`, `bank_sel` and `prev_bank`.
- R2: When several request lines are high, the unit takes the lowest-numbered one and reports its index on `irq_src` during the strobe.
- R3: If `vec_valid` is high in the cycle a request is first accepted in the idle state, `take_irq` pulses in the next cycle. During that pulse `handler_pc` equals the bus value sampled in the accept cycle, with bit 0 cleared.
- R4: If `vec_valid` is low in the accept cycle, `tbl_rd_en` is high in that same cycle with `tbl_rd_addr = tbl_base + 4*index`. `take_irq` then pulses two cycles after the accept cycle, and `handler_pc` equals the table word returned for that address, with bit 0 cleared.
- R5: `handler_pc` bit 0 is 0 whenever `take_irq` is high.
- R6: In the cycle after the strobe, `bank_sel` equals bit 0 of the taken vector (0 for the primary bank, 1 for the alternate bank), and `prev_bank` equals the `bank_sel` value from before the strobe.
- R7: While `irq_en` is low in the idle state, raised requests start no entry: no strobe is given, no table read is issued and the bank bits do not change.
- R8: When `bank_wr_en` is high and no strobe is being given, `bank_sel` takes the value of `bank_wr_val` in the next cycle and `prev_bank` keeps its value.
- R9: `take_irq` is never high in two consecutive cycles, and at most one entry is in progress at a time.
- R10: A device-supplied vector never produces a table read. A table read happens only on the default path, and no acknowledge cycle exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_en | input | 1 | Global interrupt enable, sampled in the idle state |
| irq_req | input | NUM_SRC | Request lines, one per source; line 0 has the highest priority |
| vec_valid | input | 1 | The device is driving its own vector on `vec_data` this cycle |
| vec_data | input | VEC_W | Data-bus value holding the device-supplied vector |
| tbl_base | input | VEC_W | Base address of the default vector table |
| tbl_rd_en | output | 1 | Table read request |
| tbl_rd_addr | output | VEC_W | Table read address |
| tbl_rd_data | input | VEC_W | Table read data, valid one cycle after `tbl_rd_en` |
| bank_wr_en | input | 1 | Software write of the bank select |
| bank_wr_val | input | 1 | Value for the software bank write |
| take_irq | output | 1 | One-cycle strobe: the core jumps to `handler_pc` |
| handler_pc | output | VEC_W | Handler address with bit 0 cleared |
| irq_src | output | IDX_W | Index of the source being taken |
| bank_sel | output | 1 | Active register bank (0 primary, 1 alternate) |
| prev_bank | output | 1 | Bank select saved at the last entry |

## Verification
The bench builds the unit with its default parameters: 128 sources and 32-bit vectors. This brings source 127 within reach, whose table address lies 508 bytes above the base, so the full index-to-offset scaling is exercised. Random request patterns with one to three bits set are mixed with random bus vectors, and the bus vector is random even when `vec_valid` is low. Both entry paths and both values of bit 0 are covered, and a stray bus value could not reach the handler address unnoticed.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FETCH = 2'd1,
        S_TAKE  = 2'd2
    } ent_state_e;
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N = 128,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] req,
    output logic         any,
    output logic [W-1:0] idx
);
    // Scan from the top down so the lowest set bit is written last.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = W'(i);
            end
        end
    end

    // R2: the reported winner must itself be a pending line
    always_comb begin
        if (any) begin
            p_pick_pending_r2: assert (req[idx]);
        end
    end
endmodule

// File: rtl/irq_bank_ctl.sv
module irq_bank_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic entry_ld,
    input  logic entry_bank,
    input  logic sw_wr,
    input  logic sw_val,
    output logic bank,
    output logic bank_saved
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank       <= 1'b0;
            bank_saved <= 1'b0;
        end else if (entry_ld) begin
            bank_saved <= bank;
            bank       <= entry_bank;
        end else if (sw_wr) begin
            bank       <= sw_val;
        end
    end

    p_saved_old_r6: assert property (@(posedge clk) disable iff (!rst_n)
        entry_ld |=> bank_saved == $past(bank));
    p_sw_keeps_saved_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr && !entry_ld) |=> (bank == $past(sw_val)) && $stable(bank_saved));
endmodule

// File: rtl/irq_entry_unit.sv
module irq_entry_unit
    import irq_entry_pkg::*;
#(
    parameter int NUM_SRC = 128,
    parameter int VEC_W   = 32,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               irq_en,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic               vec_valid,
    input  logic [VEC_W-1:0]   vec_data,
    input  logic [VEC_W-1:0]   tbl_base,
    output logic               tbl_rd_en,
    output logic [VEC_W-1:0]   tbl_rd_addr,
    input  logic [VEC_W-1:0]   tbl_rd_data,
    input  logic               bank_wr_en,
    input  logic               bank_wr_val,
    output logic               take_irq,
    output logic [VEC_W-1:0]   handler_pc,
    output logic [IDX_W-1:0]   irq_src,
    output logic               bank_sel,
    output logic               prev_bank
);
    localparam int ENTRY_SHIFT = 2;

    ent_state_e st_q, st_d;
    logic             any_req;
    logic [IDX_W-1:0] win_idx;
    logic [IDX_W-1:0] src_q;
    logic [VEC_W-1:0] vec_q;
    logic             accept;

    irq_prio_pick #(.N(NUM_SRC), .W(IDX_W)) u_pick (
        .req (irq_req),
        .any (any_req),
        .idx (win_idx)
    );

    assign accept = (st_q == S_IDLE) && irq_en && any_req;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // Next state and outputs
    always_comb begin
        st_d        = st_q;
        tbl_rd_en   = 1'b0;
        tbl_rd_addr = tbl_base + (VEC_W'(win_idx) << ENTRY_SHIFT);
        take_irq    = 1'b0;
        unique case (st_q)
            S_IDLE: begin
                if (accept) begin
                    if (vec_valid) begin
                        st_d = S_TAKE;
                    end else begin
                        st_d      = S_FETCH;
                        tbl_rd_en = 1'b1;
                    end
                end
            end
            S_FETCH: st_d = S_TAKE;
            S_TAKE: begin
                take_irq = 1'b1;
                st_d     = S_IDLE;
            end
            default: st_d = S_IDLE;
        endcase
    end

    // Vector and source capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q <= '0;
            src_q <= '0;
        end else begin
            if (accept) begin
                src_q <= win_idx;
                if (vec_valid) vec_q <= vec_data;
            end
            if (st_q == S_FETCH) vec_q <= tbl_rd_data;
        end
    end

    assign handler_pc = {vec_q[VEC_W-1:1], 1'b0};
    assign irq_src    = src_q;

    irq_bank_ctl u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .entry_ld   (take_irq),
        .entry_bank (vec_q[0]),
        .sw_wr      (bank_wr_en),
        .sw_val     (bank_wr_val),
        .bank       (bank_sel),
        .bank_saved (prev_bank)
    );

    p_pc_even_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> !handler_pc[0]);
    p_take_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |=> !take_irq);
    p_fetch_then_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_rd_en |=> !take_irq ##1 take_irq);
    p_direct_no_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_IDLE && vec_valid) |-> !tbl_rd_en);
    p_direct_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && vec_valid) |=> take_irq && handler_pc == {$past(vec_data[VEC_W-1:1]), 1'b0});
    p_bank_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |=> bank_sel == $past(vec_q[0]));
    p_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_IDLE && !irq_en) |-> !tbl_rd_en ##1 !take_irq);
endmodule

// File: tb/irq_entry_unit_test.sv
module irq_entry_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 128;
    localparam int VW   = 32;
    localparam int IW   = $clog2(NSRC);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            irq_en = 1'b0;
    logic [NSRC-1:0] irq_req = '0;
    logic            vec_valid = 1'b0;
    logic [VW-1:0]   vec_data = '0;
    logic [VW-1:0]   tbl_base = 32'h0000_4000;
    logic            tbl_rd_en;
    logic [VW-1:0]   tbl_rd_addr;
    logic [VW-1:0]   tbl_rd_data = '0;
    logic            bank_wr_en = 1'b0;
    logic            bank_wr_val = 1'b0;
    logic            take_irq;
    logic [VW-1:0]   handler_pc;
    logic [IW-1:0]   irq_src;
    logic            bank_sel;
    logic            prev_bank;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_entry_unit uut (
        .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .irq_req(irq_req),
        .vec_valid(vec_valid), .vec_data(vec_data), .tbl_base(tbl_base),
        .tbl_rd_en(tbl_rd_en), .tbl_rd_addr(tbl_rd_addr), .tbl_rd_data(tbl_rd_data),
        .bank_wr_en(bank_wr_en), .bank_wr_val(bank_wr_val), .take_irq(take_irq),
        .handler_pc(handler_pc), .irq_src(irq_src), .bank_sel(bank_sel),
        .prev_bank(prev_bank)
    );

    function automatic logic [VW-1:0] tbl_word(input logic [VW-1:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_1235;
    endfunction

    function automatic int lowest(input logic [NSRC-1:0] r);
        for (int i = 0; i < NSRC; i++) if (r[i]) return i;
        return -1;
    endfunction

    // Bench model of the synchronous table memory: one cycle latency
    always @(posedge clk) if (tbl_rd_en) tbl_rd_data <= tbl_word(tbl_rd_addr);

    task automatic chk(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // One entry attempt; inputs change just after a falling edge
    task automatic attempt(input logic [NSRC-1:0] req, input logic vv,
                           input logic [VW-1:0] vd, input logic en);
        logic old_bank;
        logic old_prev;
        int   src;
        logic [VW-1:0] vec;
        old_bank = bank_sel;
        old_prev = prev_bank;
        @(negedge clk);
        irq_req = req; vec_valid = vv; vec_data = vd; irq_en = en;
        #1;
        src = lowest(req);
        if (!en || src < 0) begin
            chk("R7 no read while disabled", {31'b0, tbl_rd_en}, 32'd0);
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                chk("R7 no strobe while disabled", {31'b0, take_irq}, 32'd0);
            end
            chk("R7 bank unchanged", {30'b0, prev_bank, bank_sel}, {30'b0, old_prev, old_bank});
            irq_req = '0; irq_en = 1'b0;
            return;
        end
        if (vv) begin
            chk("R10 direct path no read", {31'b0, tbl_rd_en}, 32'd0);
            vec = vd;
            @(negedge clk);
            vec_valid = 1'b0; vec_data = $urandom;
            chk("R3 strobe next cycle", {31'b0, take_irq}, 32'd1);
        end else begin
            chk("R4 read issued", {31'b0, tbl_rd_en}, 32'd1);
            chk("R4 read address", tbl_rd_addr, tbl_base + 32'(src) * 4);
            vec = tbl_word(tbl_base + 32'(src) * 4);
            @(negedge clk);
            chk("R4 no strobe during fetch", {31'b0, take_irq}, 32'd0);
            @(negedge clk);
            chk("R4 strobe after fetch", {31'b0, take_irq}, 32'd1);
        end
        chk(vv ? "R3 handler address" : "R4 handler address", handler_pc, {vec[VW-1:1], 1'b0});
        chk("R5 address bit0 clear", {31'b0, handler_pc[0]}, 32'd0);
        chk("R2 lowest source wins", 32'(irq_src), 32'(src));
        irq_req = '0;
        @(negedge clk);
        chk("R9 single strobe", {31'b0, take_irq}, 32'd0);
        chk("R6 bank from vector bit0", {31'b0, bank_sel}, {31'b0, vec[0]});
        chk("R6 previous bank saved", {31'b0, prev_bank}, {31'b0, old_bank});
    endtask

    task automatic sw_bank(input logic v);
        logic old_prev;
        old_prev = prev_bank;
        @(negedge clk);
        bank_wr_en = 1'b1; bank_wr_val = v;
        @(negedge clk);
        bank_wr_en = 1'b0;
        chk("R8 software bank write", {31'b0, bank_sel}, {31'b0, v});
        chk("R8 saved bank kept", {31'b0, prev_bank}, {31'b0, old_prev});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL R9 watchdog act=hung exp=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [NSRC-1:0] r;
        void'($urandom(32'd1234));
        #(CLK_PERIOD * 2 + 2);
        chk("R1 reset take", {31'b0, take_irq}, 32'd0);
        chk("R1 reset read", {31'b0, tbl_rd_en}, 32'd0);
        chk("R1 reset banks", {30'b0, prev_bank, bank_sel}, 32'd0);
        rst_n = 1'b1;

        // Directed corners
        attempt({NSRC{1'b1}}, 1'b1, 32'h0000_1235, 1'b1);
        r = '0; r[NSRC-1] = 1'b1;
        attempt(r, 1'b0, 32'hFFFF_FFFF, 1'b1);
        attempt({NSRC{1'b1}}, 1'b0, 32'h0, 1'b1);
        attempt({NSRC{1'b1}}, 1'b1, 32'h0, 1'b0);
        attempt(r, 1'b1, 32'h8000_0001, 1'b1);
        sw_bank(1'b0);
        sw_bank(1'b1);

        // Constrained random
        for (int t = 0; t < 300; t++) begin
            r = '0;
            for (int b = 0; b < 1 + int'($urandom_range(2, 0)); b++)
                r[$urandom_range(NSRC - 1, 0)] = 1'b1;
            attempt(r, 1'($urandom), $urandom, ($urandom_range(7, 0) != 0));
            if ($urandom_range(9, 0) == 0) sw_bank(1'($urandom));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule